// File: doc/BRIEF.md
# Delayed Read Retry Tracker

This block sits on the target side of a shared bus and serves reads from an external master on a retry basis. The first read of an address is not answered with data. The master is told to retry, and the block asks the local memory side for the data item through a request/valid handshake. When the data arrives it is held in a single buffer. A later read of the same address completes with the held data and frees the buffer. A read of any other address while the buffer is busy is also told to retry, and it does not start a second fetch.

Held data does not wait forever. A timer starts when the fetched data is captured. If the master has not returned after 2^TMO_W clocks (32768 with the default width), the block drops the data, returns to idle and sets a sticky expired-wait flag. Software clears the flag by writing a 1 to it. The flag only reports the event: nothing else changes and the next read starts a fresh fetch.

Top module: `drd_tracker`

## Requirements
- R1: A read sampled while the block is idle is answered with `rd_retry` on the next cycle. From that cycle `fetch_req` is high and `fetch_addr` equals the read address, and both hold until a cycle in which `fetch_valid` is sampled high.
- R2: While a fetch is outstanding, every read is answered with `rd_retry`, whatever its address. This includes a read sampled in the same cycle as `fetch_valid`.
- R3: While data is held, a read whose address equals the pending address is answered one cycle later with `rd_ack` and `rd_data` equal to the fetched `fetch_data`. The buffer is then free, so `fetch_req` stays low and the next read starts a new fetch.
- R4: While data is held, a read of a different address is answered with `rd_retry`. No new fetch starts and the held data stays available.
- R5: Each sampled `rd_req` gets exactly one one-cycle response on the next cycle: either `rd_ack` or `rd_retry`, never both. Neither output is raised without a request.
- R6: Data is held for at most 2^TMO_W cycles, counting the cycle after `fetch_valid` as the first. A matching read sampled in the last of those cycles still completes. If no matching read arrives, the data is discarded at the end of that cycle and `tmo_flag` is high from the next cycle.
- R7: After a discard, a read of the same address is answered with `rd_retry` and starts a fresh fetch.
- R8: `tmo_flag` is sticky. It clears on a cycle with `sts_wr_en`=1 and `sts_wr_bit`=1. A status write with `sts_wr_bit`=0 leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R9: During and after synchronous reset (`rst_n` low), `rd_ack`, `rd_retry`, `fetch_req` and `tmo_flag` are 0.
- R10: A `fetch_valid` pulse while no fetch is outstanding is ignored. The block stays idle, and the next read is retried and starts a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | One-cycle read request from the external master |
| rd_addr | input | ADDR_W | Address of the read request |
| rd_retry | output | 1 | Request answered with retry (one cycle) |
| rd_ack | output | 1 | Request completed with data (one cycle) |
| rd_data | output | DATA_W | Read data, valid while `rd_ack` is high |
| fetch_req | output | 1 | Internal fetch request, held until `fetch_valid` |
| fetch_addr | output | ADDR_W | Address to fetch, valid with `fetch_req` |
| fetch_valid | input | 1 | Fetched data present on `fetch_data` |
| fetch_data | input | DATA_W | Fetched data item |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_bit | input | 1 | Written value for the expired-wait flag (1 clears) |
| tmo_flag | output | 1 | Sticky expired-wait flag |

## Verification
The assertions check on every cycle that the responses are exclusive and follow requests one for one, that the fetch address stays steady while a fetch is requested, that the buffer is released on completion, that held data never outlives the wait window, and that the flag only rises after a timer expiry and stays set until a clearing write. Which response a read gets is left to the bench scenarios: a retry during a fetch or for a foreign address, and an ack for the pending address with the right data. So are a read that lands exactly in the last held cycle, a fresh fetch after a discard, and the effect of a status write whose bit is 0.

// File: rtl/drd_pkg.sv
// Package: shared types of the delayed-read tracker.
// Assumes: nothing beyond SystemVerilog 2017.
package drd_pkg;

    // Tracker phase: idle, waiting for internal data, holding data.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HOLD  = 2'd2
    } drd_state_e;

    // Answer given to a bus read request.
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_ACK   = 2'd2
    } drd_rsp_e;

endpackage

// File: rtl/drd_timer.sv
// Module: drd_timer
// Counts the cycles the buffer has held fetched data and flags the last
// allowed cycle.
// Assumes: run is high exactly while data is held. The count restarts at
// zero whenever run drops, so each hold period is timed afresh.
module drd_timer #(
    parameter int TMO_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam logic [TMO_W-1:0] LAST = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;

    // Age counter: cleared while idle, advances once per held cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry marks the final cycle of the hold window.
    always_comb begin
        expire = run && (cnt_q == LAST);
    end

endmodule

// File: rtl/drd_pending.sv
// Module: drd_pending
// Holds the address and data of the single outstanding delayed read,
// compares incoming reads against it and registers the read data port.
// Assumes: load_addr and load_data never fire in the same cycle. The
// control decides when the stored values are meaningful.
module drd_pending #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              load_data,
    input  logic [DATA_W-1:0] new_data,
    input  logic              present,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              addr_hit,
    output logic [DATA_W-1:0] out_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] out_q;

    // Capture the address of the read that opens a delayed transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_addr) begin
            addr_q <= req_addr;
        end
    end

    // Capture the data item returned by the internal fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_data) begin
            data_q <= new_data;
        end
    end

    // Drive held data onto the bus-side data port when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (present) begin
            out_q <= data_q;
        end
    end

    // Address comparison for retried reads.
    always_comb begin
        addr_hit  = (req_addr == addr_q);
        pend_addr = addr_q;
        out_data  = out_q;
    end

endmodule

// File: rtl/drd_status.sv
// Module: drd_status
// Sticky expired-wait flag with write-one-to-clear access.
// Assumes: set is a one-cycle event. A set in the same cycle as a
// clearing write wins, so no event is lost.
module drd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    logic flag_q;

    // Flag update: set has priority over a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (wr_en && wr_bit) begin
            flag_q <= 1'b0;
        end
    end

    // Expose the stored flag.
    always_comb begin
        flag = flag_q;
    end

endmodule

// File: rtl/drd_ctrl.sv
// Module: drd_ctrl
// Phase control of the delayed-read tracker. It decides retry or
// completion for each read, starts fetches, captures returned data and
// discards held data on expiry. Responses are registered, so they appear
// one cycle after the request.
// Assumes: rd_req is a one-cycle strobe per bus read attempt, and
// fetch_valid is only meaningful while a fetch is requested.
module drd_ctrl
    import drd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       addr_hit,
    input  logic       fetch_valid,
    input  logic       expire,
    output drd_state_e state,
    output logic       start,
    output logic       capture,
    output logic       present,
    output logic       discard,
    output logic       ack,
    output logic       retry
);
    drd_state_e state_q;
    drd_state_e state_d;
    drd_rsp_e   rsp;
    logic       ack_q;
    logic       retry_q;

    // Next phase and per-cycle actions.
    always_comb begin
        state_d = state_q;
        rsp     = RSP_NONE;
        start   = 1'b0;
        capture = 1'b0;
        discard = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    start   = 1'b1;
                    rsp     = RSP_RETRY;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_req) begin
                    rsp = RSP_RETRY;
                end
                if (fetch_valid) begin
                    capture = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (rd_req && addr_hit) begin
                    rsp     = RSP_ACK;
                    state_d = ST_IDLE;
                end else begin
                    if (rd_req) begin
                        rsp = RSP_RETRY;
                    end
                    if (expire) begin
                        discard = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        present = (rsp == RSP_ACK);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered one-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            ack_q   <= (rsp == RSP_ACK);
            retry_q <= (rsp == RSP_RETRY);
        end
    end

    // Output mapping.
    always_comb begin
        state = state_q;
        ack   = ack_q;
        retry = retry_q;
    end

endmodule

// File: rtl/drd_tracker.sv
// Module: drd_tracker (top)
// Target-side tracker for retry-based reads. It answers reads with retry
// or data, runs the internal fetch handshake, times out stale data after
// 2^TMO_W held cycles and records the timeout in a sticky flag.
// Assumes: a single outstanding delayed read, and fetch_data valid in the
// cycle fetch_valid is high.
module drd_tracker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_retry,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic              sts_wr_en,
    input  logic              sts_wr_bit,
    output logic              tmo_flag
);
    import drd_pkg::*;

    drd_state_e state;
    logic       start;
    logic       capture;
    logic       present;
    logic       discard;
    logic       addr_hit;
    logic       expire;
    logic       held;

    drd_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .addr_hit    (addr_hit),
        .fetch_valid (fetch_valid),
        .expire      (expire),
        .state       (state),
        .start       (start),
        .capture     (capture),
        .present     (present),
        .discard     (discard),
        .ack         (rd_ack),
        .retry       (rd_retry)
    );

    drd_pending #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_addr (start),
        .req_addr  (rd_addr),
        .load_data (capture),
        .new_data  (fetch_data),
        .present   (present),
        .pend_addr (fetch_addr),
        .addr_hit  (addr_hit),
        .out_data  (rd_data)
    );

    drd_timer #(
        .TMO_W (TMO_W)
    ) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (held),
        .expire (expire)
    );

    drd_status sts_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (discard),
        .wr_en  (sts_wr_en),
        .wr_bit (sts_wr_bit),
        .flag   (tmo_flag)
    );

    // Phase decode for the fetch request and the hold timer.
    always_comb begin
        fetch_req = (state == ST_FETCH);
        held      = (state == ST_HOLD);
    end

endmodule

// File: rtl/drd_tracker_chk.sv
// Module: drd_tracker_chk
// Property checker for drd_tracker, attached by bind below. It watches the
// ports together with the hold phase and the timer expiry.
// Assumes: synchronous active-low reset as in the design.
module drd_tracker_chk #(
    parameter int TMO_W = 15
) (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_ack,
    input logic rd_retry,
    input logic fetch_req,
    input logic fetch_valid,
    input logic [63:0] fetch_addr_w,
    input logic sts_wr_en,
    input logic sts_wr_bit,
    input logic tmo_flag,
    input logic held,
    input logic expire
);
    localparam logic [TMO_W:0] LAST_OK = {1'b0, {TMO_W{1'b1}}};

    logic [TMO_W:0] hold_cnt;

    // Independent count of consecutive held cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (held) begin
            hold_cnt <= hold_cnt + 1'b1;
        end else begin
            hold_cnt <= '0;
        end
    end

    a_r5_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && rd_retry));

    a_r5_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_ack || rd_retry));

    a_r5_no_unasked_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || rd_retry) |-> $past(rd_req));

    a_r1_fetch_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && $past(fetch_req)) |-> $stable(fetch_addr_w));

    a_r1_fetch_drops_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid) |=> !fetch_req);

    a_r3_ack_frees_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (!fetch_req && !held));

    a_r6_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (hold_cnt <= LAST_OK));

    a_r6_flag_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(expire));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !(sts_wr_en && sts_wr_bit)) |=> tmo_flag);

endmodule

bind drd_tracker drd_tracker_chk #(
    .TMO_W (TMO_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_ack       (rd_ack),
    .rd_retry     (rd_retry),
    .fetch_req    (fetch_req),
    .fetch_valid  (fetch_valid),
    .fetch_addr_w (64'(fetch_addr)),
    .sts_wr_en    (sts_wr_en),
    .sts_wr_bit   (sts_wr_bit),
    .tmo_flag     (tmo_flag),
    .held         (held),
    .expire       (expire)
);

// File: tb/drd_tracker_tb_top.sv
// Bench for drd_tracker: a behavioural reference model updated at each
// rising edge and compared with the outputs at every falling edge, plus
// scenario checks for the boundary cases.
module drd_tracker_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TMO_W  = 15;
    localparam int LIMIT  = 1 << TMO_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_retry;
    logic              rd_ack;
    logic [DATA_W-1:0] rd_data;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_valid = 1'b0;
    logic [DATA_W-1:0] fetch_data = '0;
    logic              sts_wr_en = 1'b0;
    logic              sts_wr_bit = 1'b0;
    logic              tmo_flag;

    int  errs = 0;
    int  checks = 0;
    bit  cmp_en = 1'b0;
    bit  spur = 1'b0;
    int  fdelay = 3;
    int  fwait = 0;

    // reference model state
    bit                m_busy = 0, m_have = 0, m_ack = 0, m_retry = 0, m_flag = 0;
    int                m_age = 0;
    logic [ADDR_W-1:0] m_paddr = '0;
    logic [DATA_W-1:0] m_pdata = '0, m_data = '0;

    always #5 clk = ~clk;

    drd_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_retry(rd_retry), .rd_ack(rd_ack), .rd_data(rd_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .sts_wr_en(sts_wr_en), .sts_wr_bit(sts_wr_bit), .tmo_flag(tmo_flag)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit b0, h0, done;
        int a0;
        b0 = m_busy; h0 = m_have; a0 = m_age; done = 0;
        m_ack = 0; m_retry = 0;
        if (!rst_n) begin
            m_busy = 0; m_have = 0; m_age = 0; m_flag = 0;
        end else begin
            if (rd_req) begin
                if (!b0) begin
                    m_busy = 1; m_have = 0; m_paddr = rd_addr; m_retry = 1;
                end else if (h0 && rd_addr == m_paddr) begin
                    m_ack = 1; m_data = m_pdata; m_busy = 0; m_have = 0; done = 1;
                end else begin
                    m_retry = 1;
                end
            end
            if (b0 && !h0 && fetch_valid) begin
                m_have = 1; m_age = 0; m_pdata = fetch_data;
            end
            if (h0 && !done) begin
                if (a0 == LIMIT - 1) begin
                    m_busy = 0; m_have = 0; m_flag = 1;
                end else begin
                    m_age = a0 + 1;
                end
            end
            if (!(h0 && !done && a0 == LIMIT - 1) && sts_wr_en && sts_wr_bit)
                m_flag = 0;
        end
    end

    // Cycle compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(rd_ack === m_ack, "R3 ack", 64'(rd_ack), 64'(m_ack));
            check(rd_retry === m_retry, "R2 retry", 64'(rd_retry), 64'(m_retry));
            check(tmo_flag === m_flag, "R8 flag", 64'(tmo_flag), 64'(m_flag));
            check(fetch_req === (m_busy && !m_have), "R1 fetch_req",
                  64'(fetch_req), 64'(m_busy && !m_have));
            if (m_ack)
                check(rd_data === m_data, "R3 data", 64'(rd_data), 64'(m_data));
            if (m_busy && !m_have)
                check(fetch_addr === m_paddr, "R1 fetch_addr", 64'(fetch_addr), 64'(m_paddr));
        end
    end

    // Internal memory responder: answers a fetch after fdelay cycles.
    always @(negedge clk) begin
        if (spur) begin
            fetch_valid = 1'b1;
            fetch_data  = 32'hDEAD_0000;
        end else if (fetch_req && !fetch_valid && fwait >= fdelay) begin
            fetch_valid = 1'b1;
            fetch_data  = mem_word(fetch_addr);
            fwait = 0;
        end else begin
            fetch_valid = 1'b0;
            if (fetch_req) fwait++;
            else fwait = 0;
        end
    end

    // One read attempt; returns the response seen on the next cycle.
    task automatic do_read(input logic [ADDR_W-1:0] a, output bit ack, output bit rty);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        ack = rd_ack; rty = rd_retry;
    endtask

    task automatic wait_held();
        int n = 0;
        while (!m_have && n < 100) begin @(negedge clk); n++; end
    endtask

    initial begin
        bit ack, rty;
        repeat (5) @(negedge clk);
        // R9: reset state
        check(rd_ack === 0 && rd_retry === 0, "R9 resp", {rd_ack, rd_retry}, 0);
        check(fetch_req === 0, "R9 fetch_req", 64'(fetch_req), 0);
        check(tmo_flag === 0, "R9 flag", 64'(tmo_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R1: first read retried and fetch begins
        fdelay = 3;
        do_read(16'h1234, ack, rty);
        check(rty && !ack, "R1 retry", {ack, rty}, 1);
        check(fetch_req === 1 && fetch_addr === 16'h1234, "R1 fetch",
              {fetch_req, fetch_addr}, {1'b1, 16'h1234});
        // R2: reread during fetch is retried
        do_read(16'h1234, ack, rty);
        check(rty && !ack, "R2 retry during fetch", {ack, rty}, 1);
        wait_held();
        // R4: foreign address retried, no new fetch
        do_read(16'h0042, ack, rty);
        check(rty && !ack, "R4 retry foreign", {ack, rty}, 1);
        check(fetch_req === 0, "R4 no fetch", 64'(fetch_req), 0);
        // R3: matching read completes with data
        do_read(16'h1234, ack, rty);
        check(ack && !rty, "R3 ack", {ack, rty}, 2);
        check(rd_data === mem_word(16'h1234), "R3 data", 64'(rd_data), 64'(mem_word(16'h1234)));
        @(negedge clk);
        check(fetch_req === 0, "R3 buffer free", 64'(fetch_req), 0);
        do_read(16'h1234, ack, rty);
        check(rty && !ack, "R3 next read fetches again", {ack, rty}, 1);
        wait_held();
        do_read(16'h1234, ack, rty);

        // R10: spurious fetch_valid while idle is ignored
        repeat (2) @(negedge clk);
        spur = 1'b1; @(negedge clk); spur = 1'b0;
        @(negedge clk);
        check(fetch_req === 0 && rd_ack === 0, "R10 idle kept", {fetch_req, rd_ack}, 0);
        do_read(16'h0777, ack, rty);
        check(rty && !ack && fetch_req === 1, "R10 fresh fetch", {ack, rty, fetch_req}, 3);

        // R2: read in the same cycle as fetch_valid is still retried
        fdelay = 1;
        wait (fetch_valid === 1'b1);
        do_read(16'h0777, ack, rty);
        check(rty && !ack, "R2 retry on valid cycle", {ack, rty}, 1);

        // R6: read in the last held cycle completes
        while (m_age != LIMIT - 1) @(negedge clk);
        do_read(16'h0777, ack, rty);
        check(ack && !rty && rd_data === mem_word(16'h0777), "R6 last cycle ack",
              64'(rd_data), 64'(mem_word(16'h0777)));
        check(tmo_flag === 0, "R6 no flag", 64'(tmo_flag), 0);

        // R6: no return, data discarded and flag raised
        do_read(16'h0BEE, ack, rty);
        wait_held();
        while (m_age != LIMIT - 1) @(negedge clk);
        check(tmo_flag === 0, "R6 flag not early", 64'(tmo_flag), 0);
        @(negedge clk);
        check(tmo_flag === 1, "R6 flag set", 64'(tmo_flag), 1);
        // R7: same address after discard starts a fresh fetch
        do_read(16'h0BEE, ack, rty);
        check(rty && !ack && fetch_req === 1, "R7 fresh fetch", {ack, rty, fetch_req}, 3);
        wait_held();
        do_read(16'h0BEE, ack, rty);
        check(ack && tmo_flag === 1, "R7 completes, flag kept", {ack, tmo_flag}, 3);

        // R8: write of 0 keeps flag, write of 1 clears it
        sts_wr_en = 1; sts_wr_bit = 0; @(negedge clk);
        sts_wr_en = 0; @(negedge clk);
        check(tmo_flag === 1, "R8 write0 keeps", 64'(tmo_flag), 1);
        sts_wr_en = 1; sts_wr_bit = 1; @(negedge clk);
        sts_wr_en = 0; sts_wr_bit = 0; @(negedge clk);
        check(tmo_flag === 0, "R8 write1 clears", 64'(tmo_flag), 0);

        // R8: set and clear in the same cycle, set wins
        do_read(16'h0C0C, ack, rty);
        wait_held();
        while (m_age != LIMIT - 1) @(negedge clk);
        sts_wr_en = 1; sts_wr_bit = 1; @(negedge clk);
        sts_wr_en = 0; sts_wr_bit = 0;
        check(tmo_flag === 1, "R8 set beats clear", 64'(tmo_flag), 1);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule